// File: doc/BRIEF.md
# Decode-Stage Stall Detector for a Pipeline Without Bypassing

This block decides, each cycle, whether the instruction sitting in decode of a five-stage in-order pipeline may advance. The pipeline has no bypass paths, so an operand can be read only once its producer has written the register file. When either source register of the decoding instruction names a register that an older instruction in execute or in memory is still going to write, the detector freezes the program counter and the fetch/decode register and injects a bubble into execute.

The execute-stage producer's destination is picked inside the block: an arithmetic instruction writes the register named in its rd field, a load writes the register named in its rt field. The memory-stage producer's destination arrives already selected. The register file writes in the first half of a cycle and reads in the second, so an instruction in writeback never causes a hold. The logic is purely combinational; its outputs follow its inputs within the same cycle.

Top module: `hazard_stall_unit`

## Requirements
- R1: When ex_wen is 1, the execute-stage destination is nonzero and equals id_src_a or id_src_b, the outputs are pc_write=0, ifid_write=0, bubble=1 in the same cycle.
- R2: The execute-stage destination is ex_rd_field when ex_is_load=0 and ex_rt_field when ex_is_load=1; the unselected field never causes a hold.
- R3: When mem_wen is 1, mem_dst is nonzero and equals id_src_a or id_src_b, the outputs signal a hold (pc_write=0).
- R4: Register number 0 is never a dependence: a zero destination never causes a hold.
- R5: For every input, ifid_write equals pc_write and bubble equals the inverse of pc_write.
- R6: A producer whose write enable is 0 never causes a hold, whatever its destination.
- R7: Both source operands are compared independently; a match on either one alone causes a hold, and no match on both gives pc_write=1.
- R8: In a pipeline built around the block, a consumer directly behind its producer is held for exactly 2 cycles, one instruction further back for 1 cycle, and two instructions further back for 0 cycles, for both arithmetic and load producers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_W | First source register number of the decoding instruction |
| id_src_b | input | REG_W | Second source register number of the decoding instruction |
| ex_rd_field | input | REG_W | rd field held in the decode-to-execute register |
| ex_rt_field | input | REG_W | rt field held in the decode-to-execute register |
| ex_is_load | input | 1 | Execute-stage instruction is a load (destination is rt) |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | REG_W | Selected destination held in the execute-to-memory register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| pc_write | output | 1 | 1 lets the program counter advance |
| ifid_write | output | 1 | 1 lets the fetch/decode register load |
| bubble | output | 1 | 1 zeroes the control fields entering execute |

## Verification
A vector table applies single-cycle input combinations: a match on each source alone, matches only in execute or only in memory, a load whose rt is matched against one whose rd is matched, producers with write enable low, register zero on both sides and the largest register number. These separate the execute path from the memory path, the rd/rt selection from a fixed field, and qualification by enable and nonzero destination from a bare equality. A clocked model of the pipeline registers then runs producer/consumer pairs at distances one, two and three, which tells a detector that sees both later stages from one that sees only execute or that also holds on writeback.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   // which instruction field carries the execute-stage destination
   typedef enum logic {
      DST_FROM_RD = 1'b0,
      DST_FROM_RT = 1'b1
   } dst_sel_e;

   // the three pipeline-freeze controls
   typedef struct packed {
      logic pc_we;
      logic ifid_we;
      logic bubble;
   } hz_ctrl_t;

endpackage

// File: rtl/hzd_dest_pick.sv
module hzd_dest_pick
   import hzd_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic [REG_W-1:0] rd_field,
   input  logic [REG_W-1:0] rt_field,
   input  logic             is_load,
   output logic [REG_W-1:0] dst
);

   dst_sel_e sel;

   assign sel = is_load ? DST_FROM_RT : DST_FROM_RD;

   always_comb begin
      unique case (sel)
         DST_FROM_RT: dst = rt_field;
         default:     dst = rd_field;
      endcase
   end

   // R2: a load must name its rt field as destination
   always_comb begin
      if (is_load) begin
         p_load_uses_rt_r2: assert (dst == rt_field)
            else $error("load destination not taken from rt");
      end
   end

endmodule

// File: rtl/hzd_operand_cmp.sv
module hzd_operand_cmp #(
   parameter int REG_W         = 5,
   parameter int NUM_SRC       = 2,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_W-1:0] srcs,
   input  logic [REG_W-1:0]              dst,
   input  logic                          wen,
   output logic                          hit
);

   logic               dst_live;
   logic [NUM_SRC-1:0] match;

   // variant: register zero either hardwired (never a dependence) or ordinary
   generate
      if (ZERO_IS_CONST) begin : g_zero_const
         assign dst_live = |dst;
      end else begin : g_zero_plain
         assign dst_live = 1'b1;
      end
   endgenerate

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         assign match[g] = wen && dst_live && (srcs[g] == dst);
      end
   endgenerate

   assign hit = |match;

   // R6: a disabled producer cannot create a dependence
   always_comb begin
      if (!wen) begin
         p_no_wen_no_hit_r6: assert (!hit)
            else $error("hit reported for non-writing producer");
      end
   end

endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
   import hzd_pkg::*;
(
   input  logic     ex_hit,
   input  logic     mem_hit,
   output hz_ctrl_t ctrl
);

   logic hold;

   assign hold         = ex_hit | mem_hit;
   assign ctrl.pc_we   = ~hold;
   assign ctrl.ifid_we = ~hold;
   assign ctrl.bubble  = hold;

endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
   import hzd_pkg::*;
#(
   parameter int REG_W         = 5,
   parameter bit ZERO_IS_CONST = 1'b1
) (
   input  logic [REG_W-1:0] id_src_a,
   input  logic [REG_W-1:0] id_src_b,
   input  logic [REG_W-1:0] ex_rd_field,
   input  logic [REG_W-1:0] ex_rt_field,
   input  logic             ex_is_load,
   input  logic             ex_wen,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wen,
   output logic             pc_write,
   output logic             ifid_write,
   output logic             bubble
);

   localparam int NUM_SRC = 2;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_width
         $error("REG_W must lie between 1 and 8");
      end
   endgenerate

   logic [NUM_SRC-1:0][REG_W-1:0] srcs;
   logic [REG_W-1:0]              ex_dst;
   logic                          ex_hit;
   logic                          mem_hit;
   hz_ctrl_t                      ctrl;

   assign srcs[0] = id_src_a;
   assign srcs[1] = id_src_b;

   hzd_dest_pick #(.REG_W(REG_W)) u_pick (
      .rd_field (ex_rd_field),
      .rt_field (ex_rt_field),
      .is_load  (ex_is_load),
      .dst      (ex_dst)
   );

   hzd_operand_cmp #(
      .REG_W(REG_W), .NUM_SRC(NUM_SRC), .ZERO_IS_CONST(ZERO_IS_CONST)
   ) u_cmp_ex (
      .srcs (srcs),
      .dst  (ex_dst),
      .wen  (ex_wen),
      .hit  (ex_hit)
   );

   hzd_operand_cmp #(
      .REG_W(REG_W), .NUM_SRC(NUM_SRC), .ZERO_IS_CONST(ZERO_IS_CONST)
   ) u_cmp_mem (
      .srcs (srcs),
      .dst  (mem_dst),
      .wen  (mem_wen),
      .hit  (mem_hit)
   );

   hzd_stall_ctrl u_ctrl (
      .ex_hit  (ex_hit),
      .mem_hit (mem_hit),
      .ctrl    (ctrl)
   );

   assign pc_write   = ctrl.pc_we;
   assign ifid_write = ctrl.ifid_we;
   assign bubble     = ctrl.bubble;

   // port-level checks across the submodules
   always_comb begin
      // R3: memory-stage dependence holds decode
      if (mem_wen && (mem_dst != '0) && (mem_dst == id_src_a || mem_dst == id_src_b)) begin
         p_mem_dep_holds_r3: assert (!pc_write)
            else $error("memory-stage dependence not held");
      end
      // R1: execute-stage R-type dependence holds decode
      if (ex_wen && !ex_is_load && (ex_rd_field != '0) &&
          (ex_rd_field == id_src_a || ex_rd_field == id_src_b)) begin
         p_ex_dep_holds_r1: assert (!pc_write && bubble)
            else $error("execute-stage dependence not held");
      end
      // R4: zero sources can never depend on anything
      if (ZERO_IS_CONST && id_src_a == '0 && id_src_b == '0) begin
         p_zero_src_free_r4: assert (pc_write)
            else $error("hold raised on register zero");
      end
      // R6: no writer in flight means no hold
      if (!ex_wen && !mem_wen) begin
         p_idle_free_r6: assert (pc_write)
            else $error("hold without any writing producer");
      end
      // R5: control outputs stay coherent
      p_ctrl_coherent_r5: assert (ifid_write == pc_write && bubble != pc_write)
         else $error("freeze controls disagree");
   end

endmodule

// File: tb/sim_hazard_stall_unit.sv
module sim_hazard_stall_unit;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [4:0] id_src_a, id_src_b, ex_rd_field, ex_rt_field, mem_dst;
   logic       ex_is_load, ex_wen, mem_wen;
   logic       pc_write, ifid_write, bubble;

   hazard_stall_unit u0 (
      .id_src_a(id_src_a), .id_src_b(id_src_b),
      .ex_rd_field(ex_rd_field), .ex_rt_field(ex_rt_field),
      .ex_is_load(ex_is_load), .ex_wen(ex_wen),
      .mem_dst(mem_dst), .mem_wen(mem_wen),
      .pc_write(pc_write), .ifid_write(ifid_write), .bubble(bubble)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [3:0] req;
      logic [4:0] a, b, rd, rt;
      logic       ld, wen;
      logic [4:0] md;
      logic       mwen;
      logic       hold;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{4'd1, 5'd1,  5'd2,  5'd1,  5'd9,  1'b0, 1'b1, 5'd0,  1'b0, 1'b1}, // R1 src a vs rd
      '{4'd7, 5'd3,  5'd4,  5'd4,  5'd9,  1'b0, 1'b1, 5'd0,  1'b0, 1'b1}, // R7 src b alone
      '{4'd7, 5'd3,  5'd4,  5'd7,  5'd9,  1'b0, 1'b1, 5'd0,  1'b0, 1'b0}, // R7 no match
      '{4'd2, 5'd5,  5'd6,  5'd9,  5'd5,  1'b1, 1'b1, 5'd0,  1'b0, 1'b1}, // R2 load via rt
      '{4'd2, 5'd5,  5'd6,  5'd5,  5'd9,  1'b1, 1'b1, 5'd0,  1'b0, 1'b0}, // R2 rd ignored for load
      '{4'd2, 5'd5,  5'd6,  5'd9,  5'd5,  1'b0, 1'b1, 5'd0,  1'b0, 1'b0}, // R2 rt ignored for R-type
      '{4'd3, 5'd8,  5'd2,  5'd0,  5'd0,  1'b0, 1'b0, 5'd8,  1'b1, 1'b1}, // R3 mem vs src a
      '{4'd3, 5'd8,  5'd2,  5'd0,  5'd0,  1'b0, 1'b0, 5'd2,  1'b1, 1'b1}, // R3 mem vs src b
      '{4'd6, 5'd8,  5'd2,  5'd0,  5'd0,  1'b0, 1'b0, 5'd8,  1'b0, 1'b0}, // R6 mem disabled
      '{4'd6, 5'd1,  5'd2,  5'd1,  5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0}, // R6 ex disabled
      '{4'd4, 5'd0,  5'd0,  5'd0,  5'd0,  1'b0, 1'b1, 5'd0,  1'b1, 1'b0}, // R4 all zero
      '{4'd4, 5'd0,  5'd3,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b0}, // R4 zero dst
      '{4'd1, 5'd31, 5'd31, 5'd31, 5'd0,  1'b0, 1'b1, 5'd0,  1'b0, 1'b1}, // R1 top register
      '{4'd7, 5'd12, 5'd13, 5'd14, 5'd15, 1'b0, 1'b1, 5'd16, 1'b1, 1'b0}  // R7 busy, no match
   };

   // clocked model of the pipeline registers around the detector
   typedef struct packed {
      logic [4:0] sa, sb, dst;
      logic       ld, wen;
   } ins_t;

   ins_t prog [16];
   ins_t ifid, idex;
   logic [4:0] exm_dst;
   logic       exm_wen;
   int         pc;

   function automatic void drive_from_model();
      id_src_a    = ifid.sa;
      id_src_b    = ifid.sb;
      ex_rd_field = idex.ld ? 5'd0 : idex.dst;
      ex_rt_field = idex.ld ? idex.dst : idex.sb;
      ex_is_load  = idex.ld;
      ex_wen      = idex.wen;
      mem_dst     = exm_dst;
      mem_wen     = exm_wen;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 16; i++) prog[i] = '0;
      ifid = '0; idex = '0; exm_dst = '0; exm_wen = 1'b0; pc = 0;
      drive_from_model();
   endtask

   task automatic run_dist(input int d, input bit ld, input bit use_b, output int holds);
      model_clear();
      prog[0] = '{sa: 5'd1, sb: 5'd2, dst: 5'd10, ld: ld, wen: 1'b1};
      for (int i = 1; i < d; i++)
         prog[i] = '{sa: 5'd3, sb: 5'd4, dst: 5'(20 + i), ld: 1'b0, wen: 1'b1};
      prog[d] = use_b ? '{sa: 5'd5, sb: 5'd10, dst: 5'd11, ld: 1'b0, wen: 1'b1}
                      : '{sa: 5'd10, sb: 5'd5, dst: 5'd11, ld: 1'b0, wen: 1'b1};
      holds = 0;
      drive_from_model();
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         #5;
         if (!pc_write) holds++;
         exm_dst = idex.ld ? idex.dst : idex.dst;
         exm_wen = idex.wen;
         if (!pc_write) idex = '0;
         else idex = ifid;
         if (pc_write) begin
            ifid = prog[pc];
            pc++;
         end
         drive_from_model();
      end
   endtask

   bit done = 1'b0;

   initial begin
      int h;
      // reset state: empty pipeline registers
      model_clear();
      @(negedge clk);
      #5;
      chk(pc_write == 1'b1 && ifid_write == 1'b1 && bubble == 1'b0,
          "R6 reset state", {pc_write, ifid_write, bubble}, 3'b110);

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         id_src_a = VECS[v].a;  id_src_b = VECS[v].b;
         ex_rd_field = VECS[v].rd; ex_rt_field = VECS[v].rt;
         ex_is_load = VECS[v].ld; ex_wen = VECS[v].wen;
         mem_dst = VECS[v].md; mem_wen = VECS[v].mwen;
         #5;
         chk(pc_write == !VECS[v].hold, $sformatf("R%0d vector %0d", VECS[v].req, v),
             pc_write, !VECS[v].hold);
         chk(ifid_write == pc_write && bubble == !pc_write,
             $sformatf("R5 vector %0d", v), {ifid_write, bubble}, {pc_write, !pc_write});
      end

      // R8: hold length versus producer distance
      run_dist(1, 1'b0, 1'b0, h); chk(h == 2, "R8 distance 1 arith", h, 2);
      run_dist(2, 1'b0, 1'b0, h); chk(h == 1, "R8 distance 2 arith", h, 1);
      run_dist(3, 1'b0, 1'b0, h); chk(h == 0, "R8 distance 3 arith", h, 0);
      run_dist(1, 1'b1, 1'b0, h); chk(h == 2, "R8 distance 1 load", h, 2);
      run_dist(2, 1'b1, 1'b1, h); chk(h == 1, "R8 distance 2 load src b", h, 1);
      run_dist(3, 1'b1, 1'b1, h); chk(h == 0, "R8 distance 3 load src b", h, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule